// File: doc/BRIEF.md
# Phase-Arbitrated Shared Memory Decoder

This block sits between an 8-bit processor with a 16-bit address bus, a shared static RAM, and a video fetch engine. It splits the processor address space into four equal segments using the two top address bits, and produces the chip selects for the program ROM, the keyboard input buffer and the video mode register. It also steers the RAM address bus between the processor and the video fetch engine.

A phase counter runs on the master clock and divides it by four to form the processor clock E. The video engine owns the RAM while E is low. The processor owns it while E is high, but only when it addresses the RAM segment, so neither side ever waits. Every select is qualified by E being high. The RAM write strobe is narrowed further by an external window strobe, so it never overlaps a changing address or data. An address bit above the 4K RAM blocks writes, so the small RAM does not alias across its whole segment. An external disable input lets an expansion device take the map over.

Top module: `shmem_decoder`

## Requirements
- R1: E (`e_clk`) is low for two master clock cycles and then high for two, repeating. `addr_strobe` is high only in the first low cycle of each E period.
- R2: With address bits [15:14] equal to 11 the ROM select is driven; 01 is the RAM segment; 10 is the I/O segment; 00 drives no select.
- R3: `rom_sel`, `kbd_rd`, `vmode_wr` and `cpu_buf_en` are never high while E is low.
- R4: Whenever `cpu_buf_en` is low, `ram_addr` equals `vid_addr`. When it is high, `ram_addr` equals `cpu_addr[11:0]`.
- R5: `cpu_buf_en` is high exactly when E is high, the address is in the RAM segment and `exp_disable` is low.
- R6: `ram_we_n` (active low) is low only when `cpu_buf_en` is high, `cpu_rd_wr` is 0 (write) and `win_strobe` is high.
- R7: A RAM-segment write with address bit 12 set leaves `ram_we_n` high.
- R8: In the I/O segment with E high, `cpu_rd_wr`=1 (read) drives `kbd_rd` and `cpu_rd_wr`=0 (write) drives `vmode_wr`. The two are never high together.
- R9: While `exp_disable` is high, no select, buffer enable or write strobe is asserted.
- R10: `bank_sel` is one-hot at all times. Bit 1 is high when `ram_addr[11]` is 1, and bit 0 is high when it is 0.
- R11: During reset the phase counter holds its first phase: `e_clk` is low, `addr_strobe` is high and all selects are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd_wr | input | 1 | 1 = read, 0 = write |
| win_strobe | input | 1 | Write-safety window strobe |
| vid_addr | input | 12 | Video fetch address |
| exp_disable | input | 1 | Expansion takeover, active high |
| e_clk | output | 1 | Processor clock E |
| addr_strobe | output | 1 | Address latch strobe, in the low phase of E |
| ram_addr | output | 12 | Address presented to the shared RAM |
| ram_we_n | output | 1 | RAM write strobe, active low |
| bank_sel | output | 2 | One-hot RAM bank enable |
| rom_sel | output | 1 | ROM chip select |
| kbd_rd | output | 1 | Keyboard buffer read enable |
| vmode_wr | output | 1 | Video mode register write pulse |
| cpu_buf_en | output | 1 | Routes the processor address and data onto the RAM |

## Verification
The hardest case to reach is a write into the RAM segment in which every qualifier but one is met. This covers E high without the window, the window without E, and everything met with address bit 12 set. Only the missing qualifier should keep the write strobe inactive. The stimulus reaches these cases by aligning to a chosen E phase: it waits at falling master-clock edges until E has the level the vector needs, then drives the address, direction, window and disable together, and checks within the same phase. Each near-miss case is its own vector next to the vector in which the write is fully qualified.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
   typedef enum logic [1:0] {
      SEG_LOW  = 2'b00,
      SEG_RAM  = 2'b01,
      SEG_IO   = 2'b10,
      SEG_ROM  = 2'b11
   } seg_e;

   typedef struct packed {
      logic rom;
      logic kbd;
      logic vmode;
      logic ram;
   } sel_t;
endpackage

// File: rtl/shmem_phase_gen.sv
module shmem_phase_gen #(
   parameter int PHASES = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic e_hi,
   output logic strobe
);
   localparam int CW   = (PHASES > 2) ? $clog2(PHASES) : 1;
   localparam int HALF = PHASES / 2;
   localparam logic [CW-1:0] LAST = CW'(PHASES - 1);
   localparam logic [CW-1:0] MID  = CW'(HALF);

   generate
      if (PHASES < 2 || (PHASES % 2) != 0) begin : g_bad
         $error("PHASES must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt == LAST)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign e_hi   = (cnt >= MID);
   assign strobe = (cnt == '0);
endmodule

// File: rtl/shmem_seg_decode.sv
module shmem_seg_decode
   import shmem_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd_wr,
   input  logic              e_hi,
   input  logic              exp_disable,
   output sel_t              sel
);
   generate
      if (ADDR_W < 4) begin : g_bad
         $error("ADDR_W too small");
      end
   endgenerate

   seg_e seg;
   logic qual;

   assign seg  = seg_e'(cpu_addr[ADDR_W-1 -: 2]);
   assign qual = e_hi & ~exp_disable;

   always_comb begin
      sel = '0;
      if (qual) begin
         unique case (seg)
            SEG_RAM: sel.ram   = 1'b1;
            SEG_IO: begin
               sel.kbd   = cpu_rd_wr;
               sel.vmode = ~cpu_rd_wr;
            end
            SEG_ROM: sel.rom   = 1'b1;
            default: sel       = '0;
         endcase
      end
   end

   logic unused_lo;
   assign unused_lo = ^cpu_addr[ADDR_W-3:0];
endmodule

// File: rtl/shmem_ram_arb.sv
module shmem_ram_arb #(
   parameter int ADDR_W      = 16,
   parameter int RAM_AW      = 12,
   parameter int BANKS       = 2,
   parameter bit ALIAS_GUARD = 1'b1
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd_wr,
   input  logic              win_strobe,
   input  logic              ram_granted,
   input  logic [RAM_AW-1:0] vid_addr,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we_n,
   output logic [BANKS-1:0]  bank_sel
);
   localparam int BB = (BANKS > 1) ? $clog2(BANKS) : 1;

   generate
      if (BANKS < 2 || (1 << BB) != BANKS) begin : g_bad_banks
         $error("BANKS must be a power of two, at least 2");
      end
      if (RAM_AW + 2 >= ADDR_W) begin : g_bad_aw
         $error("RAM_AW leaves no guard bit below the segment bits");
      end
   endgenerate

   logic blocked;

   generate
      if (ALIAS_GUARD) begin : g_guard
         assign blocked = cpu_addr[RAM_AW];
      end else begin : g_noguard
         assign blocked = 1'b0;
      end
   endgenerate

   assign ram_addr = ram_granted ? cpu_addr[RAM_AW-1:0] : vid_addr;
   assign ram_we_n = ~(ram_granted & ~cpu_rd_wr & win_strobe & ~blocked);

   logic [BB-1:0] bank_idx;
   assign bank_idx = ram_addr[RAM_AW-1 -: BB];

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         assign bank_sel[b] = (bank_idx == BB'(b));
      end
   endgenerate

   logic unused_hi;
   assign unused_hi = ^cpu_addr[ADDR_W-1:RAM_AW+1] ^ (ALIAS_GUARD ? 1'b0 : cpu_addr[RAM_AW]);
endmodule

// File: rtl/shmem_decoder.sv
module shmem_decoder
   import shmem_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int RAM_AW      = 12,
   parameter int BANKS       = 2,
   parameter int PHASES      = 4,
   parameter bit ALIAS_GUARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd_wr,
   input  logic              win_strobe,
   input  logic [RAM_AW-1:0] vid_addr,
   input  logic              exp_disable,
   output logic              e_clk,
   output logic              addr_strobe,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we_n,
   output logic [BANKS-1:0]  bank_sel,
   output logic              rom_sel,
   output logic              kbd_rd,
   output logic              vmode_wr,
   output logic              cpu_buf_en
);
   logic e_hi;
   sel_t sel;

   shmem_phase_gen #(.PHASES(PHASES)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .e_hi   (e_hi),
      .strobe (addr_strobe)
   );

   shmem_seg_decode #(.ADDR_W(ADDR_W)) u_seg (
      .cpu_addr    (cpu_addr),
      .cpu_rd_wr   (cpu_rd_wr),
      .e_hi        (e_hi),
      .exp_disable (exp_disable),
      .sel         (sel)
   );

   shmem_ram_arb #(
      .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .BANKS(BANKS), .ALIAS_GUARD(ALIAS_GUARD)
   ) u_arb (
      .cpu_addr    (cpu_addr),
      .cpu_rd_wr   (cpu_rd_wr),
      .win_strobe  (win_strobe),
      .ram_granted (sel.ram),
      .vid_addr    (vid_addr),
      .ram_addr    (ram_addr),
      .ram_we_n    (ram_we_n),
      .bank_sel    (bank_sel)
   );

   assign e_clk      = e_hi;
   assign rom_sel    = sel.rom;
   assign kbd_rd     = sel.kbd;
   assign vmode_wr   = sel.vmode;
   assign cpu_buf_en = sel.ram;
endmodule

// File: rtl/shmem_decoder_chk.sv
module shmem_decoder_chk #(
   parameter int ADDR_W = 16,
   parameter int RAM_AW = 12,
   parameter int BANKS  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_rd_wr,
   input logic              win_strobe,
   input logic [RAM_AW-1:0] vid_addr,
   input logic              exp_disable,
   input logic              e_clk,
   input logic              addr_strobe,
   input logic [RAM_AW-1:0] ram_addr,
   input logic              ram_we_n,
   input logic [BANKS-1:0]  bank_sel,
   input logic              rom_sel,
   input logic              kbd_rd,
   input logic              vmode_wr,
   input logic              cpu_buf_en
);
   a_r1_strobe_low_e: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |-> !e_clk);
   a_r1_e_high_two: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(e_clk) |=> e_clk);
   a_r3_sel_in_e_high: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_sel | kbd_rd | vmode_wr | cpu_buf_en) |-> e_clk);
   a_r4_video_owns: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_buf_en |-> (ram_addr == vid_addr));
   a_r6_we_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (cpu_buf_en && !cpu_rd_wr && win_strobe));
   a_r7_guard_bit: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[RAM_AW] |-> ram_we_n);
   a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_sel, kbd_rd, vmode_wr, cpu_buf_en}));
   a_r9_takeover: assert property (@(posedge clk) disable iff (!rst_n)
      exp_disable |-> !(rom_sel | kbd_rd | vmode_wr | cpu_buf_en | !ram_we_n));
   a_r10_bank_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_sel) == 1);
endmodule

bind shmem_decoder shmem_decoder_chk #(
   .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .BANKS(BANKS)
) i_chk (.*);

// File: tb/test_shmem_decoder.sv
module test_shmem_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd_wr = 1'b1;
   logic        win_strobe = 1'b0;
   logic [11:0] vid_addr = 12'hA5C;
   logic        exp_disable = 1'b0;
   logic        e_clk, addr_strobe, ram_we_n, rom_sel, kbd_rd, vmode_wr, cpu_buf_en;
   logic [11:0] ram_addr;
   logic [1:0]  bank_sel;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   shmem_decoder i_shmem_decoder (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd_wr(cpu_rd_wr),
      .win_strobe(win_strobe), .vid_addr(vid_addr), .exp_disable(exp_disable),
      .e_clk(e_clk), .addr_strobe(addr_strobe), .ram_addr(ram_addr),
      .ram_we_n(ram_we_n), .bank_sel(bank_sel), .rom_sel(rom_sel),
      .kbd_rd(kbd_rd), .vmode_wr(vmode_wr), .cpu_buf_en(cpu_buf_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // vector: {addr, rw, win, dis, e_level, expect {rom,kbd,vmode,buf,we_n}}
   localparam int NV = 13;
   localparam logic [24:0] VEC [NV] = '{
      {16'h4123, 1'b0, 1'b1, 1'b0, 1'b1, 5'b00010},  // R6 full write
      {16'h4123, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00011},  // R6 no window
      {16'h5123, 1'b0, 1'b1, 1'b0, 1'b1, 5'b00011},  // R7 guard bit
      {16'h4123, 1'b1, 1'b1, 1'b0, 1'b1, 5'b00011},  // R5 read
      {16'h4123, 1'b0, 1'b1, 1'b0, 1'b0, 5'b00001},  // R3 E low
      {16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 5'b01001},  // R8 kbd read
      {16'h8000, 1'b0, 1'b1, 1'b0, 1'b1, 5'b00101},  // R8 mode write
      {16'hC010, 1'b1, 1'b0, 1'b0, 1'b1, 5'b10001},  // R2 rom
      {16'hC010, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00001},  // R3 rom E low
      {16'h0050, 1'b0, 1'b1, 1'b0, 1'b1, 5'b00001},  // R2 low segment
      {16'h8000, 1'b1, 1'b0, 1'b1, 1'b1, 5'b00001},  // R9 io disabled
      {16'h4800, 1'b0, 1'b1, 1'b1, 1'b1, 5'b00001},  // R9 ram disabled
      {16'h4FFF, 1'b1, 1'b0, 1'b0, 1'b1, 5'b00011}   // R10 top address
   };

   task automatic wait_e(input logic lvl);
      @(negedge clk);
      while (e_clk !== lvl) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int hi_cnt;
      int st_cnt;
      int both;
      logic [11:0] exp_ra;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 e_clk", {31'd0, e_clk}, 32'd0);
      check("R11 addr_strobe", {31'd0, addr_strobe}, 32'd1);
      check("R11 selects", {28'd0, rom_sel, kbd_rd, vmode_wr, cpu_buf_en}, 32'd0);
      rst_n = 1'b1;

      // R1 phase pattern over two E periods
      hi_cnt = 0; st_cnt = 0; both = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         hi_cnt += int'(e_clk);
         st_cnt += int'(addr_strobe);
         if (e_clk && addr_strobe) both++;
      end
      check("R1 E high cycles", hi_cnt, 32'd4);
      check("R1 strobe cycles", st_cnt, 32'd2);
      check("R1 strobe only in low E", both, 32'd0);

      for (int v = 0; v < NV; v++) begin
         wait_e(VEC[v][5]);
         cpu_addr    = VEC[v][24:9];
         cpu_rd_wr   = VEC[v][8];
         win_strobe  = VEC[v][7];
         exp_disable = VEC[v][6];
         #1;
         check($sformatf("R2/R3/R5/R6/R8/R9 vec %0d", v),
               {27'd0, rom_sel, kbd_rd, vmode_wr, cpu_buf_en, ram_we_n},
               {27'd0, VEC[v][4:0]});
         exp_ra = VEC[v][1] ? VEC[v][20:9] : vid_addr;
         check($sformatf("R4 ram_addr vec %0d", v), {20'd0, ram_addr}, {20'd0, exp_ra});
         check($sformatf("R10 bank vec %0d", v), {30'd0, bank_sel},
               exp_ra[11] ? 32'd2 : 32'd1);
      end

      // R4/R10 low video bank while E low
      wait_e(1'b0);
      vid_addr = 12'h123;
      #1;
      check("R4 video addr", {20'd0, ram_addr}, 32'h123);
      check("R10 video bank low", {30'd0, bank_sel}, 32'd1);

      // R11 reset returns to first phase
      wait_e(1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 re-reset e_clk", {31'd0, e_clk}, 32'd0);
      check("R11 re-reset strobe", {31'd0, addr_strobe}, 32'd1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule